// File: doc/BRIEF.md
# Two-Way Multi-Channel Mailbox Register Block

This block gives two processors, called A and B, a set of mailbox slots for passing a command word and a data word to each other. Each direction has a parameterised number of channels, four by default. Each channel has a command register, a data register and a one-bit slot state machine. The sender on a channel writes the command word and then the data word. The write to the data word marks the slot as holding a message. The receiver reads both words and then releases the slot by writing a one to that channel's bit in the group status register. A set bit tells the sender that the slot is busy.

Each direction also has an interrupt mask register. A single interrupt line goes toward the receiving side. It is high while any channel holds a message and has its mask bit set. Software reaches all registers over a simple 32-bit register port: an address, a write strobe, write data, and combinational read data.

Each channel slot is a two-state machine with the states EMPTY and FULL. The transition EMPTY to FULL ("post") happens on a write to the channel's data register. The transition FULL to EMPTY ("release") happens on a status write that has the channel's bit set to one. In every other case the slot holds its state. A write to the command register never moves the slot.

Top module: `mbx_regs`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: The register layout depends on the channel count NCH, so that each group spans 8+8*NCH bytes. For the A-to-B group: mask at 0x00, status at 0x04, channel n command at 0x08+8n, channel n data at 0x0C+8n. The B-to-A group uses the same layout starting at byte 0x28 (with NCH=4). Command and data registers read back the last value written. Address bits [1:0] are ignored.
- R3: A write to channel n's data register sets status bit n in the following cycle. A write to the command register alone leaves the status unchanged.
- R4: Writing the status register clears every bit n for which the write data has bit n set. Bits written as zero keep their value. A status write never sets a bit.
- R5: Mask bits [NCH-1:0] are read/write. Mask bits from NCH upward, and status bits from NCH upward, always read zero. A mask write does not change the status.
- R6: irq_to_b is high exactly when, for some n, A-to-B status bit n and A-to-B mask bit n are both set. irq_to_a is formed the same way from the B-to-A group. Both interrupts follow a register write in the next cycle.
- R7: A write into one group leaves the other group's status, mask and interrupt unchanged.
- R8: Addresses at or above 2*(8+8*NCH) read as zero, and writes to them have no effect.
- R9: Releasing a slot keeps its command and data words, which can still be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_to_a | output | 1 | Interrupt toward processor A (B-to-A group) |
| irq_to_b | output | 1 | Interrupt toward processor B (A-to-B group) |

## Verification
The assertions assume that the register port carries at most one access per cycle and that the address and write data are valid whenever the write strobe is high. They also assume a bus that never writes two different registers in the same cycle, so a post and a release of the same slot cannot coincide. The directed tasks drive every write as a single one-cycle strobe set up on the falling clock edge. They then return the strobe to zero before the next access, and they never place a data write and a status write in the same cycle. The sequences follow the normal sender order: command, then data, then a release by the receiver. The ordering cases are covered by separate tasks: a command alone, a clear with zero bits, a clear of a channel that is not pending, and writes to unmapped addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Slot state of a single mailbox channel
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    // Byte offsets inside one direction group
    localparam int unsigned MASK_OFF   = 0;
    localparam int unsigned STAT_OFF   = 4;
    localparam int unsigned HDR_BYTES  = 8;
    localparam int unsigned CH_STRIDE  = 8;
    localparam int unsigned DATA_SKEW  = 4;

endpackage

// File: rtl/mbx_chan.sv
module mbx_chan
    import mbx_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd,
    input  logic          wr_data,
    input  logic          release_i,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] data_q,
    output logic          full
);

    slot_state_e state_q, state_d;

    // next-state logic: post on data write, release on clear bit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (wr_data)                state_d = SLOT_FULL;
            SLOT_FULL:  if (release_i && !wr_data) state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        full = (state_q == SLOT_FULL);
    end

    // payload words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_cmd)  cmd_q  <= wdata;
            if (wr_data) data_q <= wdata;
        end
    end

    // R3: a data write always leaves the slot full
    p_post_sets_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> full);

    // R3: a command write alone does not move the slot
    p_cmd_keeps_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !wr_data && !release_i) |=> $stable(full));

    // R4: release empties the slot
    p_release_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !wr_data) |=> !full);

    // R4: an empty slot only fills through a data write
    p_no_spurious_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && !wr_data) |=> !full);

    // R9: release keeps the payload
    p_release_keeps_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cmd && !wr_data) |=> ($stable(cmd_q) && $stable(data_q)));

endmodule

// File: rtl/mbx_dir.sv
module mbx_dir
    import mbx_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    parameter int unsigned DW    = 32,
    parameter int unsigned OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq,
    output logic [NCH-1:0]   status,
    output logic [NCH-1:0]   mask
);

    localparam logic [OFF_W-1:0] MASK_A = OFF_W'(MASK_OFF);
    localparam logic [OFF_W-1:0] STAT_A = OFF_W'(STAT_OFF);

    logic [OFF_W-1:0] off_w;
    logic             hit_mask;
    logic             hit_stat;
    logic [DW-1:0]    cmd_arr  [NCH];
    logic [DW-1:0]    data_arr [NCH];

    assign off_w    = {off[OFF_W-1:2], 2'b00};
    assign hit_mask = wr && (off_w == MASK_A);
    assign hit_stat = wr && (off_w == STAT_A);

    // mask register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mask <= '0;
        else if (hit_mask) mask <= wdata[NCH-1:0];
    end

    genvar g;
    for (g = 0; g < NCH; g++) begin : g_ch
        localparam logic [OFF_W-1:0] CMD_A  = OFF_W'(HDR_BYTES + CH_STRIDE*g);
        localparam logic [OFF_W-1:0] DATA_A = OFF_W'(HDR_BYTES + CH_STRIDE*g + DATA_SKEW);

        logic ch_full;

        mbx_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cmd    (wr && (off_w == CMD_A)),
            .wr_data   (wr && (off_w == DATA_A)),
            .release_i (hit_stat && wdata[g]),
            .wdata     (wdata),
            .cmd_q     (cmd_arr[g]),
            .data_q    (data_arr[g]),
            .full      (ch_full)
        );

        assign status[g] = ch_full;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (off_w == MASK_A) rdata = DW'(mask);
        if (off_w == STAT_A) rdata = DW'(status);
        for (int n = 0; n < NCH; n++) begin
            if (off_w == OFF_W'(HDR_BYTES + CH_STRIDE*n))             rdata = cmd_arr[n];
            if (off_w == OFF_W'(HDR_BYTES + CH_STRIDE*n + DATA_SKEW)) rdata = data_arr[n];
        end
    end

    assign irq = |(status & mask);

    // R6: the interrupt can only rise after a write into this group
    p_irq_rise_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr));

    // R5: mask only changes on a mask write
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_mask |=> $stable(mask));

    // R3: status only changes after a write into this group
    p_status_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(status));

    // R5: a mask write leaves the status alone
    p_mask_write_keeps_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mask |=> $stable(status));

endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32,
    parameter int unsigned AW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr_en,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_to_a,
    output logic          irq_to_b
);

    localparam int unsigned GRP_BYTES = HDR_BYTES + CH_STRIDE*NCH;
    localparam int unsigned MAP_END   = 2*GRP_BYTES;
    localparam logic [AW:0] GRP_LIM   = (AW+1)'(GRP_BYTES);
    localparam logic [AW:0] END_LIM   = (AW+1)'(MAP_END);
    localparam logic [AW-1:0] B_BASE  = AW'(GRP_BYTES);

    logic          in_a, in_b;
    logic [AW-1:0] off_b;
    logic [DW-1:0] rd_a, rd_b;
    logic [NCH-1:0] sts_a, sts_b, msk_a, msk_b;

    assign in_a  = ({1'b0, bus_addr} < GRP_LIM);
    assign in_b  = !in_a && ({1'b0, bus_addr} < END_LIM);
    assign off_b = bus_addr - B_BASE;

    // A-to-B group: messages toward B
    mbx_dir #(.NCH(NCH), .DW(DW), .OFF_W(AW)) u_a2b (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr_en && in_a),
        .off    (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (rd_a),
        .irq    (irq_to_b),
        .status (sts_a),
        .mask   (msk_a)
    );

    // B-to-A group: messages toward A
    mbx_dir #(.NCH(NCH), .DW(DW), .OFF_W(AW)) u_b2a (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr_en && in_b),
        .off    (off_b),
        .wdata  (bus_wdata),
        .rdata  (rd_b),
        .irq    (irq_to_a),
        .status (sts_b),
        .mask   (msk_b)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_a)      bus_rdata = rd_a;
        else if (in_b) bus_rdata = rd_b;
    end

    // R7: writes into A-to-B leave B-to-A untouched
    p_a_write_keeps_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && in_a) |=> ($stable(sts_b) && $stable(msk_b) && $stable(irq_to_a)));

    // R7: writes into B-to-A leave A-to-B untouched
    p_b_write_keeps_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && in_b) |=> ($stable(sts_a) && $stable(msk_a) && $stable(irq_to_b)));

    // R8: unmapped writes are inert
    p_unmapped_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !in_a && !in_b) |=>
            ($stable(sts_a) && $stable(sts_b) && $stable(msk_a) && $stable(msk_b)));

    // R8: unmapped reads return zero
    p_unmapped_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_a && !in_b) |-> (bus_rdata == '0));

endmodule

// File: tb/mbx_regs_tb.sv
module mbx_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_to_a, irq_to_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mbx_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_to_a  (irq_to_a),
        .irq_to_b  (irq_to_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        for (int a = 0; a < 8'h50; a += 4) rd_chk("R1 reg after reset", 8'(a), 32'h0);
        chk("R1 irq_to_a", {31'b0, irq_to_a}, 32'h0);
        chk("R1 irq_to_b", {31'b0, irq_to_b}, 32'h0);
    endtask

    // R2 R3 R4 R6 R9: one A-to-B message on channel 1
    task automatic t_a2b_message();
        wr(8'h10, 32'hC0DE_0001);
        rd_chk("R3 cmd alone keeps status", 8'h04, 32'h0);
        wr(8'h14, 32'h1234_5678);
        rd_chk("R3 data write posts ch1", 8'h04, 32'h2);
        chk("R6 irq_to_b masked", {31'b0, irq_to_b}, 32'h0);
        wr(8'h00, 32'h2);
        chk("R6 irq_to_b raised", {31'b0, irq_to_b}, 32'h1);
        chk("R7 irq_to_a quiet", {31'b0, irq_to_a}, 32'h0);
        rd_chk("R2 cmd ch1 readback", 8'h10, 32'hC0DE_0001);
        rd_chk("R2 data ch1 readback", 8'h14, 32'h1234_5678);
        rd_chk("R2 low addr bits ignored", 8'h17, 32'h1234_5678);
        rd_chk("R7 B-to-A status untouched", 8'h2C, 32'h0);
        wr(8'h04, 32'h0);
        rd_chk("R4 zero write keeps bit", 8'h04, 32'h2);
        wr(8'h04, 32'h1);
        rd_chk("R4 other-bit clear keeps bit", 8'h04, 32'h2);
        wr(8'h04, 32'h2);
        rd_chk("R4 write-one clears", 8'h04, 32'h0);
        chk("R6 irq_to_b dropped", {31'b0, irq_to_b}, 32'h0);
        rd_chk("R9 cmd kept after release", 8'h10, 32'hC0DE_0001);
        rd_chk("R9 data kept after release", 8'h14, 32'h1234_5678);
        wr(8'h04, 32'h0000_000F);
        rd_chk("R4 status write never sets", 8'h04, 32'h0);
    endtask

    // R5: mask width and independence from status
    task automatic t_mask();
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R5 mask upper bits zero", 8'h00, 32'h0000_000F);
        rd_chk("R5 mask write keeps status", 8'h04, 32'h0);
        chk("R6 no pending no irq", {31'b0, irq_to_b}, 32'h0);
        wr(8'h00, 32'h0);
        rd_chk("R5 mask cleared", 8'h00, 32'h0);
    endtask

    // R2 R6 R7: all four B-to-A channels
    task automatic t_b2a_all();
        for (int n = 0; n < 4; n++) begin
            wr(8'(8'h30 + 8*n), 32'hA000_0000 + 32'(n));
            wr(8'(8'h34 + 8*n), 32'hB000_0000 + 32'(n));
        end
        rd_chk("R3 B-to-A four pending", 8'h2C, 32'hF);
        rd_chk("R7 A-to-B status untouched", 8'h04, 32'h0);
        for (int n = 0; n < 4; n++) begin
            rd_chk("R2 B-to-A cmd readback", 8'(8'h30 + 8*n), 32'hA000_0000 + 32'(n));
            rd_chk("R2 B-to-A data readback", 8'(8'h34 + 8*n), 32'hB000_0000 + 32'(n));
        end
        chk("R6 irq_to_a masked", {31'b0, irq_to_a}, 32'h0);
        wr(8'h28, 32'h8);
        chk("R6 irq_to_a on ch3", {31'b0, irq_to_a}, 32'h1);
        chk("R7 irq_to_b stays low", {31'b0, irq_to_b}, 32'h0);
        wr(8'h2C, 32'h8);
        chk("R6 irq_to_a off after ch3 release", {31'b0, irq_to_a}, 32'h0);
        rd_chk("R4 other B-to-A bits kept", 8'h2C, 32'h7);
        wr(8'h2C, 32'h7);
        rd_chk("R4 B-to-A cleared", 8'h2C, 32'h0);
    endtask

    // R8: unmapped space
    task automatic t_unmapped();
        wr(8'h34, 32'h5555_0000);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd_chk("R8 read 0x50 zero", 8'h50, 32'h0);
        rd_chk("R8 read 0xFC zero", 8'hFC, 32'h0);
        rd_chk("R8 B-to-A status kept", 8'h2C, 32'h1);
        rd_chk("R8 A-to-B status kept", 8'h04, 32'h0);
        rd_chk("R8 B-to-A mask kept", 8'h28, 32'h8);
        rd_chk("R8 A-to-B mask kept", 8'h00, 32'h0);
        wr(8'h2C, 32'h1);
        rd_chk("R4 final clear", 8'h2C, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_a2b_message();
        t_mask();
        t_b2a_all();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule